// File: doc/BRIEF.md
# Ternary Flow Filter with Host Mirroring

This block sits on a received-packet stream and classifies every frame against a table of ternary rules. Each rule holds a key value, a care-mask and an enable flag. The upstream parser supplies the header key and the frame's arrival timestamp with the first data word. Every frame is forwarded unchanged on the pass-through output whether it matches or not. A frame that hits at least one rule is also copied to a host output. That copy starts with the 64-bit arrival timestamp, split into two data words, ahead of the frame bytes.

The rule table has two banks of sixteen entries. Each bank finds its own hits and its own lowest hitting entry, and the two results are merged. A single-cycle write port replaces one rule at a time while traffic is running. A lookup happens once per frame, in the cycle the first word is presented, so every frame is judged against one table. The host path has a valid/ready handshake. It never holds up the pass-through path: when the host is not ready for an offered beat, the rest of that copy is abandoned and a drop counter advances.

Top module: `tflow_filter`

## Requirements
- R1: Every input word is delivered on the forward output with identical data and last flag, in order, whether or not the frame matches any rule.
- R2: Rule i hits a key when its enable bit is 1 and ((key XOR value) AND mask) equals zero. Key bits where the mask bit is 0 are ignored.
- R3: There are 32 rules. Rules 0 to 15 form one bank and rules 16 to 31 the other. A frame matches when any rule in either bank hits.
- R4: For each frame, match_strobe pulses high for exactly one cycle. With it, match_hit shows whether any rule hit, and match_rule gives the lowest-numbered hitting rule (0 when none hit).
- R5: A matching frame produces a host copy in this order: timestamp bits 63:32, then timestamp bits 31:0, then every frame word. mir_last is 1 only on the final frame word.
- R6: A frame that matches no rule produces no host-output beats.
- R7: A rule write asserted in the same cycle as a frame's lookup does not affect that frame. It applies from the next frame on. Writing with cfg_enable=0 removes the rule.
- R8: When the host output is offered a beat and mir_ready is 0, the forward path does not stall. The remaining beats of that copy are discarded and drop_count increases by exactly 1 for that frame.
- R9: After reset, no rule is enabled, drop_count is 0, and fwd_valid, mir_valid, in_ready and match_strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | 5 | Rule number to write |
| cfg_value | input | KEY_W | Rule key value |
| cfg_mask | input | KEY_W | Rule care-mask (1 = compare bit) |
| cfg_enable | input | 1 | Rule enable flag |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | DATA_W | Input word |
| in_last | input | 1 | Final word of frame |
| in_key | input | KEY_W | Header key, valid with first word |
| in_ts | input | 2*DATA_W | Arrival timestamp, valid with first word |
| fwd_valid | output | 1 | Forward word valid |
| fwd_ready | input | 1 | Forward sink ready |
| fwd_data | output | DATA_W | Forward word |
| fwd_last | output | 1 | Forward final word |
| mir_valid | output | 1 | Host copy beat valid |
| mir_ready | input | 1 | Host sink ready |
| mir_data | output | DATA_W | Host copy beat (timestamp or frame word) |
| mir_last | output | 1 | Host copy final beat |
| match_strobe | output | 1 | One-cycle lookup result pulse |
| match_hit | output | 1 | Frame matched a rule |
| match_rule | output | 5 | Lowest hitting rule number |
| drop_count | output | CNT_W | Abandoned host copies |

## Verification
The assertions assume that the upstream source keeps in_valid high, and holds in_data, in_last, in_key and in_ts steady, until a word is accepted. They also assume that key and timestamp are meaningful with the first word of each frame. The bench's driver changes these inputs only after a word has been accepted, and it presents the key and timestamp together with the first word. The sink-ready patterns run in several modes: both sinks always ready; forward ready in a repeating gap pattern; host never ready; and host ready for exactly three beats. This makes sure the abandon path is reached both at the first timestamp beat and in the middle of a frame.

// File: rtl/tflow_filter.sv
module tflow_filter #(
  parameter int RULES  = 32,
  parameter int BANK   = 16,
  parameter int KEY_W  = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [$clog2(RULES)-1:0] cfg_addr,
  input  logic [KEY_W-1:0]      cfg_value,
  input  logic [KEY_W-1:0]      cfg_mask,
  input  logic                  cfg_enable,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  in_last,
  input  logic [KEY_W-1:0]      in_key,
  input  logic [2*DATA_W-1:0]   in_ts,
  output logic                  fwd_valid,
  input  logic                  fwd_ready,
  output logic [DATA_W-1:0]     fwd_data,
  output logic                  fwd_last,
  output logic                  mir_valid,
  input  logic                  mir_ready,
  output logic [DATA_W-1:0]     mir_data,
  output logic                  mir_last,
  output logic                  match_strobe,
  output logic                  match_hit,
  output logic [$clog2(RULES)-1:0] match_rule,
  output logic [CNT_W-1:0]      drop_count
);
  localparam int NB     = RULES / BANK;
  localparam int IDX_W  = $clog2(RULES);
  localparam int BIDX_W = (BANK > 1) ? $clog2(BANK) : 1;
  localparam int TS_W   = 2 * DATA_W;

  typedef enum logic [1:0] {S_IDLE, S_TSH, S_TSL, S_BODY} st_t;

  st_t                st;
  logic               mir_on;
  logic [TS_W-1:0]    ts_q;

  logic [KEY_W-1:0]   rule_val [RULES];
  logic [KEY_W-1:0]   rule_msk [RULES];
  logic [RULES-1:0]   rule_en;

  logic [NB-1:0]      bank_any;
  logic [BIDX_W-1:0]  bank_lo [NB];
  logic               any_hit;
  logic [IDX_W-1:0]   hit_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rule_en <= '0;
    else if (cfg_we) rule_en[cfg_addr] <= cfg_enable;

  always_ff @(posedge clk)
    if (cfg_we) begin
      rule_val[cfg_addr] <= cfg_value;
      rule_msk[cfg_addr] <= cfg_mask;
    end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [BANK-1:0]   hv;
    logic [BIDX_W-1:0] lo;
    for (genvar e = 0; e < BANK; e++) begin : g_ent
      assign hv[e] = rule_en[b*BANK+e] &&
                     (((in_key ^ rule_val[b*BANK+e]) & rule_msk[b*BANK+e]) == '0);
    end
    always_comb begin
      lo = '0;
      for (int i = BANK - 1; i >= 0; i--)
        if (hv[i]) lo = BIDX_W'(i);
    end
    assign bank_any[b] = |hv;
    assign bank_lo[b]  = lo;
  end

  always_comb begin
    any_hit = |bank_any;
    hit_idx = '0;
    for (int b = NB - 1; b >= 0; b--)
      if (bank_any[b]) hit_idx = IDX_W'(b * BANK) + IDX_W'(bank_lo[b]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st           <= S_IDLE;
      mir_on       <= 1'b0;
      ts_q         <= '0;
      drop_count   <= '0;
      match_strobe <= 1'b0;
      match_hit    <= 1'b0;
      match_rule   <= '0;
    end else begin
      match_strobe <= 1'b0;
      case (st)
        S_IDLE:
          if (in_valid) begin
            ts_q         <= in_ts;
            mir_on       <= any_hit;
            match_strobe <= 1'b1;
            match_hit    <= any_hit;
            match_rule   <= hit_idx;
            st           <= any_hit ? S_TSH : S_BODY;
          end
        S_TSH:
          if (mir_ready) st <= S_TSL;
          else begin
            st         <= S_BODY;
            mir_on     <= 1'b0;
            drop_count <= drop_count + 1'b1;
          end
        S_TSL: begin
          st <= S_BODY;
          if (mir_on && !mir_ready) begin
            mir_on     <= 1'b0;
            drop_count <= drop_count + 1'b1;
          end
        end
        default:
          if (in_valid && fwd_ready) begin
            if (mir_on && !mir_ready) begin
              mir_on     <= 1'b0;
              drop_count <= drop_count + 1'b1;
            end
            if (in_last) begin
              mir_on <= 1'b0;
              st     <= S_IDLE;
            end
          end
      endcase
    end

  assign in_ready  = (st == S_BODY) && fwd_ready;
  assign fwd_valid = (st == S_BODY) && in_valid;
  assign fwd_data  = in_data;
  assign fwd_last  = in_last;

  assign mir_valid = (st == S_TSH) || (st == S_TSL && mir_on) ||
                     (st == S_BODY && mir_on && in_valid && fwd_ready);
  assign mir_data  = (st == S_TSH) ? ts_q[TS_W-1:DATA_W] :
                     (st == S_TSL) ? ts_q[DATA_W-1:0]    : in_data;
  assign mir_last  = (st == S_BODY) && in_last;
endmodule

// File: rtl/tflow_filter_chk.sv
module tflow_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             fwd_valid,
  input logic             fwd_ready,
  input logic             fwd_last,
  input logic             mir_valid,
  input logic             mir_ready,
  input logic             mir_last,
  input logic             match_strobe,
  input logic             match_hit,
  input logic [CNT_W-1:0] drop_count
);
  a_r1_forward_consumes_input: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_ready) |-> in_ready);

  a_r6_copy_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mir_valid |-> match_hit);

  a_r5_copy_ends_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_valid && mir_last) |-> (fwd_valid && fwd_last && fwd_ready));

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    match_strobe |=> !match_strobe);

  a_r8_drop_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

  a_r8_drop_only_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> $past(mir_valid && !mir_ready));
endmodule

bind tflow_filter tflow_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_last(fwd_last),
  .mir_valid(mir_valid), .mir_ready(mir_ready), .mir_last(mir_last),
  .match_strobe(match_strobe), .match_hit(match_hit), .drop_count(drop_count)
);

// File: tb/tflow_filter_test.sv
`timescale 1ns/1ps
module tflow_filter_test;
  localparam int RULES = 32, KEY_W = 32, DW = 32, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_we = 0, cfg_enable = 0;
  logic [4:0] cfg_addr = '0;
  logic [KEY_W-1:0] cfg_value = '0, cfg_mask = '0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic [KEY_W-1:0] in_key = '0;
  logic [2*DW-1:0] in_ts = '0;
  logic fwd_valid, fwd_ready = 1, fwd_last;
  logic [DW-1:0] fwd_data;
  logic mir_valid, mir_ready = 1, mir_last;
  logic [DW-1:0] mir_data;
  logic match_strobe, match_hit;
  logic [4:0] match_rule;
  logic [CW-1:0] drop_count;

  tflow_filter #(.RULES(RULES), .BANK(16), .KEY_W(KEY_W), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_value(cfg_value),
    .cfg_mask(cfg_mask), .cfg_enable(cfg_enable), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_key(in_key), .in_ts(in_ts),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_data(fwd_data), .fwd_last(fwd_last),
    .mir_valid(mir_valid), .mir_ready(mir_ready), .mir_data(mir_data), .mir_last(mir_last),
    .match_strobe(match_strobe), .match_hit(match_hit), .match_rule(match_rule),
    .drop_count(drop_count));

  int checks = 0, errors = 0;
  int cyc = 0, fr_mode = 0, mir_mode = 0, mir_cnt = 0, exp_drop = 0;
  logic [DW:0] fq[$], mq[$];
  logic [5:0]  xq[$];
  logic [KEY_W-1:0] mv [RULES], mm [RULES];
  logic me [RULES];
  logic pend_wr = 0;
  logic [4:0] pw_addr;
  logic [KEY_W-1:0] pw_val, pw_msk;
  logic pw_en;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model_look(input logic [KEY_W-1:0] k);
    for (int i = 0; i < RULES; i++)
      if (me[i] && (((k ^ mv[i]) & mm[i]) == '0)) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  // scoreboard monitor, also drives the sink readies
  initial forever begin
    @(negedge clk);
    fwd_ready = (fr_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    mir_ready = (mir_mode == 0) ? 1'b1 : (mir_mode == 1) ? 1'b0 : (mir_cnt < 3);
    cyc++;
    #1;
    if (rst_n) begin
      if (fwd_valid && fwd_ready) begin
        if (fq.size() == 0) chk(0, "R1 unexpected forward beat", {fwd_data, fwd_last}, 0);
        else begin
          logic [DW:0] e;
          e = fq.pop_front();
          chk({fwd_data, fwd_last} == e, "R1 forward beat", {fwd_data, fwd_last}, e);
        end
      end
      if (mir_valid && mir_ready) begin
        mir_cnt++;
        if (mq.size() == 0) chk(0, "R5/R6 unexpected host beat", {mir_data, mir_last}, 0);
        else begin
          logic [DW:0] e;
          e = mq.pop_front();
          chk({mir_data, mir_last} == e, "R5 host beat", {mir_data, mir_last}, e);
        end
      end
      if (match_strobe) begin
        if (xq.size() == 0) chk(0, "R4 unexpected strobe", {match_hit, match_rule}, 0);
        else begin
          logic [5:0] e;
          e = xq.pop_front();
          chk({match_hit, match_rule} == e, "R2/R3/R4 match result", {match_hit, match_rule}, e);
        end
      end
    end
  end

  task automatic wr_rule(input int a, input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] m, input logic en);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'(a); cfg_value = v; cfg_mask = m; cfg_enable = en;
    mv[a] = v; mm[a] = m; me[a] = en;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [KEY_W-1:0] key, input logic [63:0] ts, input int n, input logic [DW-1:0] base);
    logic [5:0] r;
    logic [DW:0] items[$];
    r = model_look(key);
    xq.push_back(r);
    items.push_back({ts[63:32], 1'b0});
    items.push_back({ts[31:0], 1'b0});
    for (int i = 0; i < n; i++) begin
      fq.push_back({base + DW'(i), i == n - 1});
      items.push_back({base + DW'(i), i == n - 1});
    end
    if (r[5]) begin
      if (mir_mode == 0) foreach (items[i]) mq.push_back(items[i]);
      else if (mir_mode == 2) for (int i = 0; i < 3; i++) mq.push_back(items[i]);
      if (mir_mode != 0) exp_drop++;
    end
    mir_cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 0;
      in_valid = 1; in_data = base + DW'(i); in_last = (i == n - 1);
      if (i == 0) begin
        in_key = key; in_ts = ts;
        if (pend_wr) begin
          cfg_we = 1; cfg_addr = pw_addr; cfg_value = pw_val; cfg_mask = pw_msk; cfg_enable = pw_en;
          mv[pw_addr] = pw_val; mm[pw_addr] = pw_msk; me[pw_addr] = pw_en;
          pend_wr = 0;
        end
      end
      #1;
      while (!in_ready) begin
        @(negedge clk);
        cfg_we = 0;
        #1;
      end
    end
    @(negedge clk);
    cfg_we = 0; in_valid = 0; in_last = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < RULES; i++) begin mv[i] = '0; mm[i] = '0; me[i] = 0; end
    repeat (4) @(negedge clk);
    #1;
    chk(!fwd_valid && !mir_valid && !in_ready && !match_strobe, "R9 outputs idle in reset",
        {fwd_valid, mir_valid, in_ready, match_strobe}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(drop_count == 0, "R9 drop count cleared", drop_count, 0);
    chk(!fwd_valid && !mir_valid && !in_ready, "R9 idle after reset", {fwd_valid, mir_valid, in_ready}, 0);

    // R9/R6: empty table, nothing mirrored
    send(32'h0A000001, 64'h1111_2222_3333_4444, 3, 32'h100);
    // R2: exact rule in low bank
    wr_rule(5, 32'h0A000001, 32'hFFFF_FFFF, 1);
    send(32'h0A000001, 64'hAAAA_0001_BBBB_0002, 4, 32'h200);
    // R2: one compared bit differs -> miss (R6)
    send(32'h0A000003, 64'h5, 2, 32'h300);
    // R3: prefix rule in upper bank, forward gaps
    wr_rule(20, 32'hC0A8_0000, 32'hFFFF_0000, 1);
    fr_mode = 1;
    send(32'hC0A8_1234, 64'hDEAD_BEEF_0000_0007, 5, 32'h400);
    // R4: rules 3 and 20 both hit -> 3 reported
    wr_rule(3, 32'hC0A8_5555, 32'hFFFF_0000, 1);
    send(32'hC0A8_9999, 64'h0123_4567_89AB_CDEF, 3, 32'h500);
    fr_mode = 0;
    // R5: single-word frame copy
    send(32'h0A000001, 64'hFEED_0000_0000_F00D, 1, 32'h600);
    // R7: write during lookup does not affect this frame
    pend_wr = 1; pw_addr = 7; pw_val = 32'h1111_2222; pw_msk = 32'hFFFF_FFFF; pw_en = 1;
    begin
      logic [5:0] r;
      r = model_look(32'h1111_2222);
      chk(r == 0, "R7 model precondition", r, 0);
    end
    xq.push_back(6'd0); // placeholder popped below is replaced by explicit send
    void'(xq.pop_back());
    send(32'h1111_2222, 64'h77, 2, 32'h700);
    send(32'h1111_2222, 64'h78, 2, 32'h710);
    // R7: disable rule removes it
    wr_rule(7, 32'h1111_2222, 32'hFFFF_FFFF, 0);
    send(32'h1111_2222, 64'h79, 2, 32'h720);
    // R8: host never ready -> copy dropped at first beat
    mir_mode = 1;
    send(32'h0A000001, 64'h9999_8888_7777_6666, 4, 32'h800);
    chk(drop_count == CW'(exp_drop), "R8 drop at timestamp beat", drop_count, exp_drop);
    // R8: host refuses mid-frame -> partial copy, forward intact
    mir_mode = 2; fr_mode = 1;
    send(32'hC0A8_0001, 64'h4444_3333_2222_1111, 6, 32'h900);
    chk(drop_count == CW'(exp_drop), "R8 drop mid-frame", drop_count, exp_drop);
    // R8: non-matching frame never counts a drop
    send(32'h0B00_0000, 64'h1, 3, 32'hA00);
    chk(drop_count == CW'(exp_drop), "R8 no drop without match", drop_count, exp_drop);
    mir_mode = 0; fr_mode = 0;
    send(32'hC0A8_0042, 64'h5555_6666_7777_8888, 3, 32'hB00);

    repeat (5) @(negedge clk);
    chk(fq.size() == 0, "R1 all forward beats seen", fq.size(), 0);
    chk(mq.size() == 0, "R5 all host beats seen", mq.size(), 0);
    chk(xq.size() == 0, "R4 all lookups strobed", xq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule